// File: doc/BRIEF.md
# Banked Transpose Buffer for Product-Code Encoding

This block sits between the column-side and row-side encoders of a product code. A matrix of NUM_ROWS rows by INFO_COLS columns is spread over a BANK_ROWS by BANK_COLS grid of one-bit-wide memory banks. The column side has BANK_COLS writers. The row side has BANK_ROWS readers. Each side reaches every bank it needs in the same cycle, with no conflict.

Each of the BANK_COLS writers handles one contiguous group of columns and presents one bit per beat. The block generates the bank-row enables and the address, so that column `c = g*VCOLS + vc` lands in bank-column `g` at virtual column `vc`. Matrix row `r` lands in bank-row `r / VROWS` at virtual row `r % VROWS`, where VROWS = NUM_ROWS/BANK_ROWS and VCOLS = INFO_COLS/BANK_COLS.

When the last bit of the block is stored, the block reports that it is full and refuses further writes. The row side then drains it. On each read beat every bank returns one bit from one shared address, so that reader `b` receives the nine bits of row `b*VROWS + vrow` at columns `g*VCOLS + vcol`. Issuing the final read releases the buffer for the next block.

Top module: `tpb_transpose_buf`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), wr_ready is 1, blk_full is 0 and rd_valid is 0, and the next accepted write is beat 0 of a new block.
- R2: Accepted write beat k (counting from 0 in the block) stores bit row r = k % NUM_ROWS of virtual column vc = k / NUM_ROWS. While that beat is presented, wr_bank_en is one-hot with bit (r / VROWS) set, and wr_addr equals (r % VROWS)*VCOLS + vc. Bit g of wr_data is the matrix element at row r, column g*VCOLS + vc.
- R3: blk_full is 1 from the edge that accepts beat NUM_ROWS*VCOLS-1 onward. While it is 1, wr_ready is 0, wr_bank_en is all zero, and stored contents do not change whatever wr_valid and wr_data do.
- R4: While blk_full is 0, rd_en has no effect: rd_valid stays 0.
- R5: A read is issued at a rising edge where blk_full and rd_en are both 1. rd_valid is 1 in the following cycle, and rd_vrow/rd_vcol give the virtual row and virtual column of that read.
- R6: Read beats run through virtual columns fastest and then virtual rows, so that beat j reads vrow = j / VCOLS and vcol = j % VCOLS at rd_addr = vrow*VCOLS + vcol. Bit b*BANK_COLS + g of rd_data is the matrix element at row b*VROWS + vrow, column g*VCOLS + vcol.
- R7: The edge that issues the last read (vrow = VROWS-1, vcol = VCOLS-1) clears blk_full, so wr_ready is 1 in the same cycle that rd_valid shows the last beat.
- R8: A cycle with blk_full high and rd_en low issues nothing: rd_valid is 0 in the next cycle and rd_addr holds its value.
- R9: A cycle with wr_valid low writes nothing: wr_bank_en is zero and the write position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Column writers present a beat |
| wr_data | input | BANK_COLS | One bit per column writer |
| wr_ready | output | 1 | Buffer accepts writes |
| wr_bank_en | output | BANK_ROWS | One-hot bank-row write enable of the current beat |
| wr_addr | output | AW | Bank address of the current write beat |
| blk_full | output | 1 | A complete block is stored and awaits reading |
| rd_en | input | 1 | Row side requests the next read beat |
| rd_addr | output | AW | Bank address of the next read beat |
| rd_valid | output | 1 | rd_data holds a read beat |
| rd_vrow | output | VRW | Virtual row of the beat on rd_data |
| rd_vcol | output | VCW | Virtual column of the beat on rd_data |
| rd_data | output | BANK_ROWS*BANK_COLS | Bit per bank, bank-row major |

## Verification
The properties assume that reset is applied synchronously and that wr_valid, wr_data and rd_en never carry unknown values once reset is released. They place no ordering demand on the row side: rd_en may be raised at any time, including while the buffer is still filling. The stimulus changes every input only on the falling clock edge. It raises rd_en during write stalls and presents writes while the buffer is full, so the ignore rules are exercised under legal, fully known inputs.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
   // width needed to count 0..n-1, never below one bit
   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/tpb_wr_seq.sv
module tpb_wr_seq #(
   parameter int BANK_ROWS = 6,
   parameter int VROWS     = 2,
   parameter int VCOLS     = 2,
   parameter int AW        = 2,
   localparam int BRW = tpb_pkg::bits_for(BANK_ROWS),
   localparam int VRW = tpb_pkg::bits_for(VROWS),
   localparam int VCW = tpb_pkg::bits_for(VCOLS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept_i,
   output logic [BANK_ROWS-1:0] bank_en_o,
   output logic [AW-1:0]        addr_o,
   output logic                 last_o
);
   // bit order inside a column: virtual row fastest, then bank-row
   logic [VRW-1:0] vrow_q;
   logic [BRW-1:0] brow_q;
   logic [VCW-1:0] vcol_q;

   wire vrow_end = (vrow_q == VRW'(VROWS-1));
   wire brow_end = (brow_q == BRW'(BANK_ROWS-1));
   wire vcol_end = (vcol_q == VCW'(VCOLS-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vrow_q <= '0;
         brow_q <= '0;
         vcol_q <= '0;
      end else if (accept_i) begin
         vrow_q <= vrow_end ? '0 : vrow_q + 1'b1;
         if (vrow_end) begin
            brow_q <= brow_end ? '0 : brow_q + 1'b1;
            if (brow_end)
               vcol_q <= vcol_end ? '0 : vcol_q + 1'b1;
         end
      end
   end

   assign addr_o = AW'(int'(vrow_q) * VCOLS + int'(vcol_q));
   assign last_o = accept_i & vrow_end & brow_end & vcol_end;

   for (genvar br = 0; br < BANK_ROWS; br++) begin : g_en
      assign bank_en_o[br] = accept_i & (brow_q == BRW'(br));
   end
endmodule

// File: rtl/tpb_rd_seq.sv
module tpb_rd_seq #(
   parameter int VROWS = 2,
   parameter int VCOLS = 2,
   parameter int AW    = 2,
   localparam int VRW = tpb_pkg::bits_for(VROWS),
   localparam int VCW = tpb_pkg::bits_for(VCOLS)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           issue_i,
   output logic [AW-1:0]  addr_o,
   output logic [VRW-1:0] vrow_o,
   output logic [VCW-1:0] vcol_o,
   output logic           last_o
);
   logic [VRW-1:0] vrow_q;
   logic [VCW-1:0] vcol_q;

   wire vcol_end = (vcol_q == VCW'(VCOLS-1));
   wire vrow_end = (vrow_q == VRW'(VROWS-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vrow_q <= '0;
         vcol_q <= '0;
      end else if (issue_i) begin
         vcol_q <= vcol_end ? '0 : vcol_q + 1'b1;
         if (vcol_end)
            vrow_q <= vrow_end ? '0 : vrow_q + 1'b1;
      end
   end

   assign addr_o = AW'(int'(vrow_q) * VCOLS + int'(vcol_q));
   assign vrow_o = vrow_q;
   assign vcol_o = vcol_q;
   assign last_o = issue_i & vcol_end & vrow_end;
endmodule

// File: rtl/tpb_bank_array.sv
module tpb_bank_array #(
   parameter int BANK_ROWS = 6,
   parameter int BANK_COLS = 9,
   parameter int DEPTH     = 4,
   parameter int AW        = 2
) (
   input  logic                           clk,
   input  logic [BANK_ROWS-1:0]           wr_bank_en_i,
   input  logic [AW-1:0]                  wr_addr_i,
   input  logic [BANK_COLS-1:0]           wr_bits_i,
   input  logic                           rd_en_i,
   input  logic [AW-1:0]                  rd_addr_i,
   output logic [BANK_ROWS*BANK_COLS-1:0] rd_bits_o
);
   for (genvar br = 0; br < BANK_ROWS; br++) begin : g_brow
      for (genvar bc = 0; bc < BANK_COLS; bc++) begin : g_bcol
         logic mem [DEPTH];
         logic q;
         always_ff @(posedge clk) begin
            if (wr_bank_en_i[br])
               mem[wr_addr_i] <= wr_bits_i[bc];
            if (rd_en_i)
               q <= mem[rd_addr_i];
         end
         assign rd_bits_o[br*BANK_COLS + bc] = q;
      end
   end
endmodule

// File: rtl/tpb_transpose_buf.sv
module tpb_transpose_buf #(
   parameter int NUM_ROWS  = 12,
   parameter int INFO_COLS = 18,
   parameter int BANK_ROWS = 6,
   parameter int BANK_COLS = 9,
   localparam int VROWS = NUM_ROWS / BANK_ROWS,
   localparam int VCOLS = INFO_COLS / BANK_COLS,
   localparam int DEPTH = VROWS * VCOLS,
   localparam int AW    = tpb_pkg::bits_for(DEPTH),
   localparam int VRW   = tpb_pkg::bits_for(VROWS),
   localparam int VCW   = tpb_pkg::bits_for(VCOLS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_valid,
   input  logic [BANK_COLS-1:0]           wr_data,
   output logic                           wr_ready,
   output logic [BANK_ROWS-1:0]           wr_bank_en,
   output logic [AW-1:0]                  wr_addr,
   output logic                           blk_full,
   input  logic                           rd_en,
   output logic [AW-1:0]                  rd_addr,
   output logic                           rd_valid,
   output logic [VRW-1:0]                 rd_vrow,
   output logic [VCW-1:0]                 rd_vcol,
   output logic [BANK_ROWS*BANK_COLS-1:0] rd_data
);
   if (NUM_ROWS % BANK_ROWS != 0) begin : g_bad_rows
      $error("NUM_ROWS must be a multiple of BANK_ROWS");
   end
   if (INFO_COLS % BANK_COLS != 0) begin : g_bad_cols
      $error("INFO_COLS must be a multiple of BANK_COLS");
   end
   if (BANK_ROWS < 1 || BANK_COLS < 1 || VROWS < 1 || VCOLS < 1) begin : g_bad_size
      $error("bank grid and bank depth must be non-empty");
   end

   logic           full_q;
   logic           accept, wr_last;
   logic           issue, rd_last;
   logic [VRW-1:0] seq_vrow;
   logic [VCW-1:0] seq_vcol;
   logic           valid_q;
   logic [VRW-1:0] vrow_q;
   logic [VCW-1:0] vcol_q;

   assign wr_ready = ~full_q;
   assign accept   = wr_valid & ~full_q;
   assign issue    = rd_en & full_q;

   tpb_wr_seq #(
      .BANK_ROWS(BANK_ROWS), .VROWS(VROWS), .VCOLS(VCOLS), .AW(AW)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .accept_i(accept),
      .bank_en_o(wr_bank_en), .addr_o(wr_addr), .last_o(wr_last)
   );

   tpb_rd_seq #(
      .VROWS(VROWS), .VCOLS(VCOLS), .AW(AW)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .issue_i(issue),
      .addr_o(rd_addr), .vrow_o(seq_vrow), .vcol_o(seq_vcol), .last_o(rd_last)
   );

   tpb_bank_array #(
      .BANK_ROWS(BANK_ROWS), .BANK_COLS(BANK_COLS), .DEPTH(DEPTH), .AW(AW)
   ) u_banks (
      .clk(clk), .wr_bank_en_i(wr_bank_en), .wr_addr_i(wr_addr), .wr_bits_i(wr_data),
      .rd_en_i(issue), .rd_addr_i(rd_addr), .rd_bits_o(rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q  <= 1'b0;
         valid_q <= 1'b0;
         vrow_q  <= '0;
         vcol_q  <= '0;
      end else begin
         if (wr_last)
            full_q <= 1'b1;
         else if (rd_last)
            full_q <= 1'b0;
         valid_q <= issue;
         if (issue) begin
            vrow_q <= seq_vrow;
            vcol_q <= seq_vcol;
         end
      end
   end

   assign blk_full = full_q;
   assign rd_valid = valid_q;
   assign rd_vrow  = vrow_q;
   assign rd_vcol  = vcol_q;
endmodule

// File: rtl/tpb_checker.sv
module tpb_checker #(
   parameter int BANK_ROWS = 6,
   parameter int VROWS     = 2,
   parameter int VCOLS     = 2,
   parameter int DEPTH     = 4,
   parameter int AW        = 2,
   parameter int VRW       = 1,
   parameter int VCW       = 1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_valid,
   input logic [BANK_ROWS-1:0] wr_bank_en,
   input logic [AW-1:0]        wr_addr,
   input logic                 blk_full,
   input logic                 rd_en,
   input logic [AW-1:0]        rd_addr,
   input logic                 rd_valid,
   input logic [VRW-1:0]       rd_vrow,
   input logic [VCW-1:0]       rd_vcol
);
   p_en_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_bank_en));

   p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_bank_en) |-> (int'(wr_addr) < DEPTH));

   p_full_blocks_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      blk_full |-> (wr_bank_en == '0));

   p_no_read_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_full |=> !rd_valid);

   p_valid_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_full && rd_en) |=> rd_valid);

   p_valid_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(blk_full && rd_en));

   p_release_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blk_full) |-> (rd_valid && rd_vrow == VRW'(VROWS-1) && rd_vcol == VCW'(VCOLS-1)));

   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_full && !rd_en) |=> (!rd_valid && $stable(rd_addr)));

   p_idle_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> (wr_bank_en == '0));
endmodule

bind tpb_transpose_buf tpb_checker #(
   .BANK_ROWS(BANK_ROWS), .VROWS(VROWS), .VCOLS(VCOLS), .DEPTH(DEPTH),
   .AW(AW), .VRW(VRW), .VCW(VCW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bank_en(wr_bank_en),
   .wr_addr(wr_addr), .blk_full(blk_full), .rd_en(rd_en), .rd_addr(rd_addr),
   .rd_valid(rd_valid), .rd_vrow(rd_vrow), .rd_vcol(rd_vcol)
);

// File: tb/tb_tpb_transpose_buf.sv
`timescale 1ns/1ps
module tb_tpb_transpose_buf;
   localparam int NR = 12, NC = 18, BR = 6, BC = 9;
   localparam int VR = NR / BR, VC = NC / BC;
   localparam int AW = 2, VRW = 1, VCW = 1;
   localparam int BEATS = NR * VC;
   localparam int RBEATS = VR * VC;
   // {write beat, expected bank-row, expected address}
   localparam int WTAB [8][3] = '{
      '{0, 0, 0}, '{1, 0, 2}, '{2, 1, 0}, '{3, 1, 2},
      '{11, 5, 2}, '{12, 0, 1}, '{13, 0, 3}, '{23, 5, 3}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0;
   logic [BC-1:0] wr_data = '0;
   logic rd_en = 1'b0;
   logic wr_ready, blk_full, rd_valid;
   logic [BR-1:0] wr_bank_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [VRW-1:0] rd_vrow;
   logic [VCW-1:0] rd_vcol;
   logic [BR*BC-1:0] rd_data;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tpb_transpose_buf #(.NUM_ROWS(NR), .INFO_COLS(NC), .BANK_ROWS(BR), .BANK_COLS(BC)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
      .wr_ready(wr_ready), .wr_bank_en(wr_bank_en), .wr_addr(wr_addr),
      .blk_full(blk_full), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
      .rd_vrow(rd_vrow), .rd_vcol(rd_vcol), .rd_data(rd_data));

   function automatic logic pbit(input int seed, input int r, input int c);
      int v;
      v = r * 13 + c * 7 + seed * 11 + r * c;
      return v[1] ^ v[0] ^ v[4];
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_reset_state();
      chk("R1 wr_ready after reset", 64'(wr_ready), 64'(1));
      chk("R1 blk_full after reset", 64'(blk_full), 64'(0));
      chk("R1 rd_valid after reset", 64'(rd_valid), 64'(0));
   endtask

   task automatic write_beats(input int seed, input int nbeats, input bit stall);
      for (int k = 0; k < nbeats; k++) begin
         int vc = k / NR;
         int b = k % NR;
         if (stall && (k % 5 == 2)) begin
            @(negedge clk);
            wr_valid = 1'b0;
            wr_data = '1;
            rd_en = 1'b1;
            #1 chk("R9 no enable while wr_valid low", 64'(wr_bank_en), 64'(0));
         end
         @(negedge clk);
         if (stall && (k % 5 == 2)) begin
            chk("R4 rd_en ignored while filling", 64'(rd_valid), 64'(0));
            rd_en = 1'b0;
         end
         wr_valid = 1'b1;
         for (int g = 0; g < BC; g++) wr_data[g] = pbit(seed, b, g * VC + vc);
         #1;
         for (int t = 0; t < 8; t++) begin
            if (WTAB[t][0] == k) begin
               chk("R2 bank-row enable", 64'(wr_bank_en), 64'(1) << WTAB[t][1]);
               chk("R2 write address", 64'(wr_addr), 64'(WTAB[t][2]));
            end
         end
      end
      @(negedge clk);
      wr_valid = 1'b0;
      if (nbeats == BEATS) begin
         chk("R3 blk_full after last write", 64'(blk_full), 64'(1));
         chk("R3 wr_ready low when full", 64'(wr_ready), 64'(0));
      end
   endtask

   task automatic ignored_writes(input int seed);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         wr_valid = 1'b1;
         for (int g = 0; g < BC; g++) wr_data[g] = ~pbit(seed, i, g);
         #1 chk("R3 no enable while full", 64'(wr_bank_en), 64'(0));
      end
      @(negedge clk);
      wr_valid = 1'b0;
      chk("R3 still full after ignored writes", 64'(blk_full), 64'(1));
   endtask

   task automatic check_beat(input int seed, input int k, input string dreq);
      int vrow = k / VC;
      int vcol = k % VC;
      logic [BR*BC-1:0] exp;
      for (int b = 0; b < BR; b++)
         for (int g = 0; g < BC; g++)
            exp[b * BC + g] = pbit(seed, b * VR + vrow, g * VC + vcol);
      chk("R5 rd_valid one cycle after issue", 64'(rd_valid), 64'(1));
      chk("R5 rd_vrow", 64'(rd_vrow), 64'(vrow));
      chk("R5 rd_vcol", 64'(rd_vcol), 64'(vcol));
      chk(dreq, 64'(rd_data), 64'(exp));
      if (k == RBEATS - 1) begin
         chk("R7 blk_full cleared with last beat", 64'(blk_full), 64'(0));
         chk("R7 wr_ready back", 64'(wr_ready), 64'(1));
      end
   endtask

   task automatic read_block(input int seed, input bit gap, input string dreq);
      if (!gap) begin
         @(negedge clk);
         rd_en = 1'b1;
         for (int k = 0; k < RBEATS; k++) begin
            @(negedge clk);
            if (k == RBEATS - 1) rd_en = 1'b0;
            check_beat(seed, k, dreq);
         end
      end else begin
         for (int k = 0; k < RBEATS; k++) begin
            @(negedge clk);
            rd_en = 1'b1;
            #1 chk("R6 read address order", 64'(rd_addr), 64'((k / VC) * VC + (k % VC)));
            @(negedge clk);
            rd_en = 1'b0;
            check_beat(seed, k, dreq);
            if (k < RBEATS - 1) begin
               @(negedge clk);
               chk("R8 no beat while rd_en low", 64'(rd_valid), 64'(0));
               chk("R8 read address held", 64'(rd_addr), 64'(((k + 1) / VC) * VC + ((k + 1) % VC)));
            end
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_reset_state();

      // R4: read requests before anything is stored
      rd_en = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R4 rd_en ignored while empty", 64'(rd_valid), 64'(0));
      rd_en = 1'b0;

      // block 1: stalled writes, ignored writes when full, gapped reads
      write_beats(1, BEATS, 1'b1);
      ignored_writes(1);
      read_block(1, 1'b1, "R3 R6 read data unchanged by ignored writes");

      // block 2: back-to-back writes and reads
      write_beats(2, BEATS, 1'b0);
      read_block(2, 1'b0, "R6 read data streaming");

      // partial block, then reset mid-fill
      write_beats(3, 7, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_reset_state();

      // block 3 restarts at beat 0 (table rechecked)
      write_beats(4, BEATS, 1'b0);
      read_block(4, 1'b0, "R1 R6 read data after reset restart");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule